// File: doc/BRIEF.md
# Open-Drain Display Data Channel GPIO Port

This block lets software bit-bang the two-wire display data channel (I2C clock and data) towards a monitor through one 32-bit register. For each line the register holds a value bit and an enable bit, plus a readback field that records the sensed bus levels. The lines are open-drain. The block never drives a high level. It only asserts a per-line pull-low request, which the pad turns into a low drive. Any other device on the wire can still hold a line low (wired-AND).

Software writes the register one, two or four bytes at a time, and each write is merged into the stored word. A write that counts as a bus update loads the line drivers. The same update clears the readback field and refills it with the synchronised line levels seen in that cycle. Those levels are the ones on the bus before the new drive takes effect.

Two variants are built from parameters:
- **Open variant.** Every write is a bus update.
- **Guarded variant.** An update happens only when a mask bit is set and the byte lanes of the write make a transition meaningful. This keeps multi-byte software sequences from putting false edges on the bus.

The field positions below take `BASE` as their origin. The open variant normally uses `BASE`=0. The guarded variant normally uses `BASE`=1, with its mask at `MASK_POS`=25.

Top module: `ddc_gpio_port`

## Requirements
- R1: After reset the register reads 0 and both `scl_pull` and `sda_pull` are 0 (lines released).
- R2: A write stores bytes starting at lane `wr_offset`. `wr_size` 0 writes one byte, 1 writes two bytes, and 2 or 3 writes four bytes. Source bytes come from the low end of `wr_data`, lanes beyond lane 3 are dropped, and uncovered lanes keep their value. Without a write the register does not change.
- R3: On a bus update the drivers are loaded one edge later. A line's pull output is 1 only when its enable bit is 1 and its value bit is 0. SDA uses value bit BASE and enable bit BASE+16. SCL uses value bit BASE+1 and enable bit BASE+17.
- R4: On a bus update the stored word has bits [BASE+11:BASE+8] cleared. Bit BASE+9 is then set to the sensed SCL level and bit BASE+8 to the sensed SDA level.
- R5: In the open variant (`GUARDED`=0) every write is a bus update.
- R6: In the guarded variant a write is a bus update only if bit `MASK_POS` of the merged word is 1 and one of the following holds:
  - the write covers byte lane 2, or
  - the write starts at lane 0 while bit BASE+16 or BASE+17 of the merged word is 1.
- R7: A write that is not a bus update stores the merged bytes unchanged, including the readback field, and leaves both pull outputs as they were.
- R8: The line inputs pass a two-stage synchroniser. A write on the first clock edge after a line changes still records the previous level, and a write three edges later records the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_offset | input | 2 | First byte lane of the write |
| wr_size | input | 2 | 0: one byte, 1: two bytes, 2/3: four bytes |
| wr_data | input | 32 | Write bytes, right-aligned |
| rd_data | output | 32 | Stored register value |
| scl_in | input | 1 | Sensed clock line level |
| sda_in | input | 1 | Sensed data line level |
| scl_pull | output | 1 | Pull clock line low when 1 |
| sda_pull | output | 1 | Pull data line low when 1 |

## Verification
The assertions assume that `wr_en`, `wr_offset`, `wr_size` and `wr_data` hold stable for the whole cycle around each edge. They also assume that the line inputs reflect a wired-AND of the block's own pulls and a slave's pulls. The bench meets these assumptions by changing every input on the falling edge and modelling each line as the inverse of the OR of the two pull sources. After each write it leaves three idle cycles before the next one, so the synchronised level always equals the settled line level. The synchroniser latency itself is probed only in one directed case, where the line and the write change together.

// File: rtl/ddc_gpio_pkg.sv
package ddc_gpio_pkg;

  // Byte lanes touched by a write; lanes past 3 fall off the 4-bit shift.
  function automatic logic [3:0] byte_lanes(input logic [1:0] off, input logic [1:0] sz);
    logic [3:0] span;
    case (sz)
      2'd0:    span = 4'b0001;
      2'd1:    span = 4'b0011;
      default: span = 4'b1111;
    endcase
    return span << off;
  endfunction

  // Merge right-aligned write bytes into the old word on the selected lanes.
  function automatic logic [31:0] merge_lanes(input logic [31:0] old, input logic [31:0] data,
                                              input logic [1:0] off, input logic [3:0] lanes);
    logic [31:0] shifted;
    logic [31:0] res;
    shifted = data << {off, 3'b000};
    for (int i = 0; i < 4; i++) begin
      res[i*8 +: 8] = lanes[i] ? shifted[i*8 +: 8] : old[i*8 +: 8];
    end
    return res;
  endfunction

  // Clear the four-bit readback field and place the sensed levels in it.
  function automatic logic [31:0] stamp_sense(input logic [31:0] v, input int base,
                                              input logic scl, input logic sda);
    logic [31:0] r;
    r = v;
    r[base + 8 +: 4] = 4'b0000;
    r[base + 9] = scl;
    r[base + 8] = sda;
    return r;
  endfunction

endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage [STAGES];

  // Idle bus level is high, so the chain resets to ones.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage[0] <= '1;
          else        stage[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage[s] <= '1;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage[STAGES-1];
endmodule

// File: rtl/ddc_update_gate.sv
module ddc_update_gate #(
  parameter bit GUARDED = 1'b0
) (
  input  logic wr_en,
  input  logic lane2_hit,
  input  logic at_lane0,
  input  logic mask_set,
  input  logic any_en,
  output logic bus_upd
);
  logic guard_ok;

  // Guarded variant: mask set, and either the enables' lane is written
  // or a lane-0 write lands while a line is enabled.
  assign guard_ok = mask_set & (lane2_hit | (at_lane0 & any_en));
  assign bus_upd  = wr_en & (GUARDED ? guard_ok : 1'b1);
endmodule

// File: rtl/ddc_od_driver.sv
module ddc_od_driver (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic scl_en,
  input  logic scl_val,
  input  logic sda_en,
  input  logic sda_val,
  output logic scl_pull,
  output logic sda_pull
);
  // Open-drain: only a low level is ever requested.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
    end else if (load) begin
      scl_pull <= scl_en & ~scl_val;
      sda_pull <= sda_en & ~sda_val;
    end
  end
endmodule

// File: rtl/ddc_gpio_port.sv
module ddc_gpio_port
  import ddc_gpio_pkg::*;
#(
  parameter int BASE        = 0,
  parameter bit GUARDED     = 1'b0,
  parameter int MASK_POS    = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_offset,
  input  logic [1:0]  wr_size,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_pull,
  output logic        sda_pull
);
  localparam int SDA_VAL_BIT = BASE;
  localparam int SCL_VAL_BIT = BASE + 1;
  localparam int SDA_EN_BIT  = BASE + 16;
  localparam int SCL_EN_BIT  = BASE + 17;

  logic [31:0] reg_q, reg_d, merged;
  logic [3:0]  lanes;
  logic [1:0]  sensed;          // [1] clock, [0] data
  logic        bus_upd;
  logic        mask_set, any_en;
  logic        scl_en_m, scl_val_m, sda_en_m, sda_val_m;

  assign lanes     = byte_lanes(wr_offset, wr_size);
  assign merged    = merge_lanes(reg_q, wr_data, wr_offset, lanes);
  assign mask_set  = merged[MASK_POS];
  assign scl_en_m  = merged[SCL_EN_BIT];
  assign scl_val_m = merged[SCL_VAL_BIT];
  assign sda_en_m  = merged[SDA_EN_BIT];
  assign sda_val_m = merged[SDA_VAL_BIT];
  assign any_en    = scl_en_m | sda_en_m;

  ddc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({scl_in, sda_in}),
    .sync_out (sensed)
  );

  ddc_update_gate #(.GUARDED(GUARDED)) u_gate (
    .wr_en     (wr_en),
    .lane2_hit (lanes[2]),
    .at_lane0  (wr_offset == 2'd0),
    .mask_set  (mask_set),
    .any_en    (any_en),
    .bus_upd   (bus_upd)
  );

  ddc_od_driver u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bus_upd),
    .scl_en   (scl_en_m),
    .scl_val  (scl_val_m),
    .sda_en   (sda_en_m),
    .sda_val  (sda_val_m),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull)
  );

  always_comb begin
    reg_d = reg_q;
    if (wr_en) reg_d = bus_upd ? stamp_sense(merged, BASE, sensed[1], sensed[0]) : merged;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  assign rd_data = reg_q;
endmodule

// File: rtl/ddc_gpio_port_chk.sv
module ddc_gpio_port_chk #(
  parameter int BASE     = 0,
  parameter bit GUARDED  = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        bus_upd,
  input logic        mask_set,
  input logic        scl_en_m,
  input logic        scl_val_m,
  input logic        sda_en_m,
  input logic        sda_val_m,
  input logic [31:0] rd_data,
  input logic        scl_pull,
  input logic        sda_pull
);
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data)); // R2
  AST_SCL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_upd |=> scl_pull == ($past(scl_en_m) & ~$past(scl_val_m))); // R3
  AST_SDA_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_upd |=> sda_pull == ($past(sda_en_m) & ~$past(sda_val_m))); // R3
  AST_FIELD_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_upd |=> rd_data[BASE+11:BASE+10] == 2'b00); // R4
  AST_OPEN_ALWAYS_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (GUARDED == 1'b0 && wr_en) |-> bus_upd); // R5
  AST_GUARD_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (GUARDED == 1'b1 && bus_upd) |-> mask_set); // R6
  AST_DRIVERS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_upd |=> $stable({scl_pull, sda_pull})); // R7
endmodule

bind ddc_gpio_port ddc_gpio_port_chk #(.BASE(BASE), .GUARDED(GUARDED)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .bus_upd   (bus_upd),
  .mask_set  (mask_set),
  .scl_en_m  (scl_en_m),
  .scl_val_m (scl_val_m),
  .sda_en_m  (sda_en_m),
  .sda_val_m (sda_val_m),
  .rd_data   (rd_data),
  .scl_pull  (scl_pull),
  .sda_pull  (sda_pull)
);

// File: tb/sim_ddc_gpio_port.sv
`timescale 1ns/1ps
module sim_ddc_gpio_port;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_offset, wr_size;
  logic [31:0] wr_data;
  logic [31:0] rd0, rd1;
  logic        scl_pull0, sda_pull0, scl_pull1, sda_pull1;
  logic        slv_scl [2];
  logic        slv_sda [2];
  logic        scl_line0, sda_line0, scl_line1, sda_line1;

  assign scl_line0 = ~(scl_pull0 | slv_scl[0]);
  assign sda_line0 = ~(sda_pull0 | slv_sda[0]);
  assign scl_line1 = ~(scl_pull1 | slv_scl[1]);
  assign sda_line1 = ~(sda_pull1 | slv_sda[1]);

  ddc_gpio_port #(.BASE(0), .GUARDED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_offset(wr_offset), .wr_size(wr_size),
    .wr_data(wr_data), .rd_data(rd0), .scl_in(scl_line0), .sda_in(sda_line0),
    .scl_pull(scl_pull0), .sda_pull(sda_pull0));

  ddc_gpio_port #(.BASE(1), .GUARDED(1'b1), .MASK_POS(25)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_offset(wr_offset), .wr_size(wr_size),
    .wr_data(wr_data), .rd_data(rd1), .scl_in(scl_line1), .sda_in(sda_line1),
    .scl_pull(scl_pull1), .sda_pull(sda_pull1));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_reg [2];
  logic        m_scl [2];
  logic        m_sda [2];

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Lane-by-lane write in walking order, independent of any mask arithmetic.
  function automatic logic [31:0] bench_merge(input logic [31:0] old, input logic [31:0] d,
                                              input int off, input int sz);
    logic [31:0] r = old;
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int k = 0; k < n; k++) begin
      if (off + k < 4) r[(off+k)*8 +: 8] = d[k*8 +: 8];
    end
    return r;
  endfunction

  function automatic bit bench_gate(input int port, input logic [31:0] m, input int off, input int sz);
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    bit hits2 = (off <= 2) && (off + n > 2);
    if (port == 0) return 1'b1;
    return m[25] && (hits2 || (off == 0 && (m[17] || m[18])));
  endfunction

  // Update the model for one write; line levels come from the settled bus.
  task automatic model_write(input int off, input int sz, input logic [31:0] d);
    for (int p = 0; p < 2; p++) begin
      logic [31:0] m = bench_merge(m_reg[p], d, off, sz);
      logic scl_lvl = ~(m_scl[p] | slv_scl[p]);
      logic sda_lvl = ~(m_sda[p] | slv_sda[p]);
      if (bench_gate(p, m, off, sz)) begin
        for (int b = 8; b < 12; b++) m[p+b] = 1'b0;
        m[p+9] = scl_lvl;
        m[p+8] = sda_lvl;
        m_scl[p] = m[p+17] & ~m[p+1];
        m_sda[p] = m[p+16] & ~m[p];
      end
      m_reg[p] = m;
    end
  endtask

  task automatic do_write(input int off, input int sz, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_offset = off[1:0]; wr_size = sz[1:0]; wr_data = d;
    model_write(off, sz, d);
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic compare_all(input string req);
    check(req, "u0 rd", rd0, m_reg[0]);
    check(req, "u0 pulls", {30'd0, scl_pull0, sda_pull0}, {30'd0, m_scl[0], m_sda[0]});
    check(req, "u1 rd", rd1, m_reg[1]);
    check(req, "u1 pulls", {30'd0, scl_pull1, sda_pull1}, {30'd0, m_scl[1], m_sda[1]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst_n = 1'b0; wr_en = 1'b0; wr_offset = '0; wr_size = '0; wr_data = '0;
    for (int p = 0; p < 2; p++) begin
      slv_scl[p] = 1'b0; slv_sda[p] = 1'b0;
      m_reg[p] = '0; m_scl[p] = 1'b0; m_sda[p] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all("R1");

    // R5 / R3: open port drives both low; guarded port has no mask, so R7 holds it.
    do_write(0, 2, 32'h0003_0000);
    compare_all("R3 R5 R7");
    check("R3", "u0 both pulled", {30'd0, scl_pull0, sda_pull0}, 32'd3);
    check("R7", "u1 no drive", {30'd0, scl_pull1, sda_pull1}, 32'd0);
    do_write(0, 2, 32'h0003_0003);
    compare_all("R3 released by value");
    do_write(0, 2, 32'h0000_0000);
    compare_all("R3 released by enable");

    // R6: guarded port, mask + enables (bits 17,18), values 0.
    do_write(0, 2, 32'h0206_0000);
    compare_all("R6 mask and lane2");
    check("R6", "u1 both pulled", {30'd0, scl_pull1, sda_pull1}, 32'd3);
    // R6: lane-0 write with enables set releases SCL (bit 2 is SCL value at base 1).
    do_write(0, 0, 32'h0000_0004);
    compare_all("R6 lane0 with enable");
    // R7: lane-1 write is no update on guarded port; readback field stored as written.
    do_write(1, 0, 32'h0000_001E);
    compare_all("R7 lane1 no update");
    check("R7", "u1 field as written", {28'd0, rd1[12:9]}, 32'hF);
    // R6: clearing the mask via lane 3 gives no update.
    do_write(3, 0, 32'h0000_0000);
    compare_all("R6 mask cleared");

    // R4: slave holds clock low; readback records it.
    slv_scl[0] = 1'b1; slv_scl[1] = 1'b1;
    repeat (3) @(negedge clk);
    do_write(0, 2, 32'h0000_0F00);
    compare_all("R4 sensed clock low");
    check("R4", "u0 field", {28'd0, rd0[11:8]}, 32'h1);
    slv_scl[0] = 1'b0; slv_scl[1] = 1'b0;
    repeat (3) @(negedge clk);

    // R8: data line drops in the same cycle as the write -> old level captured.
    @(negedge clk);
    wr_en = 1'b1; wr_offset = 2'd0; wr_size = 2'd2; wr_data = 32'h0000_0000;
    model_write(0, 2, 32'h0000_0000);
    slv_sda[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "u0 stale data level", {31'd0, rd0[8]}, 32'd1);
    check("R8", "u0 rd", rd0, m_reg[0]);
    do_write(0, 2, 32'h0000_0000);
    check("R8", "u0 new data level", {31'd0, rd0[8]}, 32'd0);
    compare_all("R8");
    slv_sda[0] = 1'b0;
    repeat (3) @(negedge clk);

    // Random phase: R2 merge, R5/R6 gating, R3 drive, R4 readback.
    for (int it = 0; it < 400; it++) begin
      int off = int'($urandom % 4);
      int sz  = int'($urandom % 4);
      logic [31:0] d = $urandom;
      if ($urandom % 2 == 0) d[25 - 8*off] = 1'b1;
      if ($urandom % 8 == 0) begin
        for (int p = 0; p < 2; p++) begin
          slv_scl[p] = ($urandom % 4 == 0);
          slv_sda[p] = ($urandom % 4 == 0);
        end
        repeat (3) @(negedge clk);
      end
      do_write(off, sz, d);
      compare_all("R2 R3 R4 R6 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule